// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits between the condition detectors of a serial port and the host CPU. It accepts four raw interrupt conditions: receiver line status, received data ready, transmit holding register empty and modem status. Received data ready also has a character-timeout form. A mask register, written over a simple register bus, decides which conditions may raise the single active-high interrupt line. The unit also presents an identification byte that names the most urgent enabled condition.

The identification byte is registered. While the CPU holds the identification read strobe, the byte shown stays frozen so that the value being read cannot tear. The inputs keep being sampled during that time, and once the strobe drops the byte shows the current state on the next clock. An external FIFO-mode flag sets the two top bits of the byte and enables the timeout code.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 8'h01, the mask reads 8'h00 and the interrupt output is low.
- R2: Bit 0 of the identification byte is 0 when an enabled condition was pending at the last loading edge, and 1 when none was.
- R3: Bits 2:1 name the winning condition, from highest to lowest priority: line status 2'b11, received data 2'b10, transmit empty 2'b01, modem status 2'b00.
- R4: In FIFO mode an enabled timeout produces low nibble 4'hC, with bit 3 and bit 2 both set. Timeout has the same priority as received data and wins over it. Outside FIFO mode the timeout input is ignored and bit 3 reads 0.
- R5: Bits 5:4 always read 0. Bits 7:6 read 2'b11 when FIFO mode is on and 2'b00 when it is off.
- R6: A mask write stores data bits 3:0. Bit 0 gates received data and timeout, bit 1 gates transmit empty, bit 2 gates line status and bit 3 gates modem status. Mask bits 7:4 read 0.
- R7: A masked condition affects neither the identification byte nor the interrupt output. With mask bits 3:0 all clear, the output stays low.
- R8: While the read strobe is high at a clock edge, the identification byte keeps its value. At the first edge with the strobe low, it shows the conditions and mask present at that edge.
- R9: The interrupt output is high in the same cycle as any enabled condition is pending. It follows the present mask value and is not frozen by the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoMode | input | 1 | FIFO mode enabled |
| condLine | input | 1 | Receiver line status condition |
| condRxData | input | 1 | Received data ready condition |
| condRxTimeout | input | 1 | Character timeout condition |
| condTxEmpty | input | 1 | Transmit holding register empty condition |
| condModem | input | 1 | Modem status condition |
| maskWr | input | 1 | Write strobe for the mask register |
| maskWdata | input | 8 | Write data for the mask register |
| idRead | input | 1 | Identification read strobe, high for the whole access |
| maskRdata | output | 8 | Current mask register value |
| idByte | output | 8 | Identification byte |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The bench goes after conditions that are pending at the same time. A faulty priority encoder would name transmit empty while a line status condition is waiting. It also drives timeout with FIFO mode both on and off. A design that ignored the mode would set bit 3 outside FIFO mode, and one that ranked timeout below plain received data would show 4'h4 instead of 4'hC. The bench changes conditions and writes the mask while the read strobe is held, then releases it. A design that froze too little would change the byte during the read. One that froze the interrupt line, or lost events, would show a stale value after the release. Masked conditions are raised alone, so any leak through the mask shows up as a raised interrupt line or a cleared bit 0.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int MASK_RX    = 0;
  localparam int MASK_TX    = 1;
  localparam int MASK_LINE  = 2;
  localparam int MASK_MODEM = 3;

  localparam logic [3:0] NIB_LINE    = 4'b0110;
  localparam logic [3:0] NIB_TIMEOUT = 4'b1100;
  localparam logic [3:0] NIB_RX      = 4'b0100;
  localparam logic [3:0] NIB_TX      = 4'b0010;
  localparam logic [3:0] NIB_MODEM   = 4'b0000;
  localparam logic [3:0] NIB_NONE    = 4'b0001;

  typedef struct packed {
    logic holdId;
    logic loadMask;
  } ctrlStrobes_t;

  typedef struct packed {
    logic line;
    logic rxData;
    logic rxTimeout;
    logic txEmpty;
    logic modem;
  } condVec_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic         idRead,
  input  logic         maskWr,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes.holdId   = idRead;
    strobes.loadMask = maskWr;
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MASK_W = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fifoMode,
  input  condVec_t          cond,
  output logic [DATA_W-1:0] maskOut,
  output logic [DATA_W-1:0] idOut,
  output logic              irqOut
);

  localparam int PAD_W = DATA_W - MASK_W;
  localparam logic [DATA_W-1:0] ID_RESET = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [MASK_W-1:0] maskReg;
  logic [DATA_W-1:0] idReg;
  logic [DATA_W-1:0] idNext;
  logic [3:0]        nibble;
  logic              pLine, pTimeout, pRx, pTx, pModem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (ctrl.loadMask) maskReg <= wdata[MASK_W-1:0];
  end

  assign maskOut = {{PAD_W{1'b0}}, maskReg};

  always_comb begin
    pLine    = cond.line      & maskReg[MASK_LINE];
    pTimeout = cond.rxTimeout & fifoMode & maskReg[MASK_RX];
    pRx      = cond.rxData    & maskReg[MASK_RX];
    pTx      = cond.txEmpty   & maskReg[MASK_TX];
    pModem   = cond.modem     & maskReg[MASK_MODEM];
  end

  assign irqOut = pLine | pTimeout | pRx | pTx | pModem;

  always_comb begin
    if (pLine)         nibble = NIB_LINE;
    else if (pTimeout) nibble = NIB_TIMEOUT;
    else if (pRx)      nibble = NIB_RX;
    else if (pTx)      nibble = NIB_TX;
    else if (pModem)   nibble = NIB_MODEM;
    else               nibble = NIB_NONE;
    idNext = '0;
    idNext[3:0] = nibble;
    idNext[DATA_W-1] = fifoMode;
    idNext[DATA_W-2] = fifoMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idReg <= ID_RESET;
    else if (!ctrl.holdId) idReg <= idNext;
  end

  assign idOut = idReg;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdId |=> $stable(idReg)) else $error("hold broken"); // R8

  AST_PEND_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.holdId |=> (idReg[0] == !$past(irqOut))) else $error("bit0 mismatch"); // R2

  AST_TIMEOUT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    idReg[3] |-> (idReg[2] && idReg[DATA_W-1] && idReg[DATA_W-2])) else $error("timeout code"); // R4

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irqOut) else $error("irq with mask clear"); // R7

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.holdId |=> (idReg[5:4] == 2'b00 && idReg[DATA_W-1] == $past(fifoMode))) else $error("upper bits"); // R5

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MASK_W = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              condLine,
  input  logic              condRxData,
  input  logic              condRxTimeout,
  input  logic              condTxEmpty,
  input  logic              condModem,
  input  logic              maskWr,
  input  logic [DATA_W-1:0] maskWdata,
  input  logic              idRead,
  output logic [DATA_W-1:0] maskRdata,
  output logic [DATA_W-1:0] idByte,
  output logic              irqOut
);

  ctrlStrobes_t strobes;
  condVec_t     condBus;

  assign condBus = '{line: condLine, rxData: condRxData, rxTimeout: condRxTimeout,
                     txEmpty: condTxEmpty, modem: condModem};

  uart_irq_ctrl u_ctrl (
    .idRead  (idRead),
    .maskWr  (maskWr),
    .strobes (strobes)
  );

  uart_irq_datapath #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (strobes),
    .wdata    (maskWdata),
    .fifoMode (fifoMode),
    .cond     (condBus),
    .maskOut  (maskRdata),
    .idOut    (idByte),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifo = 0, ls = 0, rx = 0, to = 0, tx = 0, ms = 0, wr = 0, rd = 0;
  logic [7:0] wd = 8'h00;
  logic [7:0] maskRdata, idByte;
  logic irqOut;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] expMask = 8'h00;
  logic [7:0] expId = 8'h01;
  string tag = "R3";

  always #2 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rstN(rstN), .fifoMode(fifo), .condLine(ls), .condRxData(rx),
    .condRxTimeout(to), .condTxEmpty(tx), .condModem(ms), .maskWr(wr),
    .maskWdata(wd), .idRead(rd), .maskRdata(maskRdata), .idByte(idByte), .irqOut(irqOut)
  );

  function automatic logic [7:0] refId(logic [7:0] m);
    logic [7:0] b;
    b = fifo ? 8'hC0 : 8'h00;
    if (ls && m[2])                b = b | 8'h06;
    else if (to && fifo && m[0])   b = b | 8'h0C;
    else if (rx && m[0])           b = b | 8'h04;
    else if (tx && m[1])           b = b | 8'h02;
    else if (ms && m[3])           b = b;
    else                           b = b | 8'h01;
    return b;
  endfunction

  function automatic logic refIrq(logic [7:0] m);
    return (ls && m[2]) || (to && fifo && m[0]) || (rx && m[0]) || (tx && m[1]) || (ms && m[3]);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a negedge with inputs already driven
  task automatic step();
    #1;
    check("R9", {7'd0, irqOut}, {7'd0, refIrq(expMask)});
    @(posedge clk);
    if (!rd) expId = refId(expMask);
    if (wr) expMask = {4'h0, wd[3:0]};
    @(negedge clk);
    check(tag, idByte, expId);
    check("R6", maskRdata, expMask);
  endtask

  task automatic setc(logic l, logic r, logic t, logic x, logic m);
    ls = l; rx = r; to = t; tx = x; ms = m;
  endtask

  task automatic writeMask(logic [7:0] v);
    wr = 1; wd = v; step(); wr = 0; wd = 8'h00;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int seed;
    repeat (3) @(negedge clk);
    check("R1", idByte, 8'h01);
    check("R1", maskRdata, 8'h00);
    check("R1", {7'd0, irqOut}, 8'h00);
    rstN = 1;
    @(negedge clk);

    // R7: conditions with mask clear
    tag = "R7";
    setc(1, 1, 1, 1, 1); fifo = 1; step(); step();
    // R6: upper mask bits dropped
    tag = "R6";
    writeMask(8'hF0); step();
    // single sources under partial masks
    tag = "R7";
    writeMask(8'h02); step();
    writeMask(8'h08); step();
    // R3 priority chain
    tag = "R3"; fifo = 0;
    writeMask(8'hFF);
    setc(1, 1, 0, 1, 1); step();
    setc(0, 1, 0, 1, 1); step();
    setc(0, 0, 0, 1, 1); step();
    setc(0, 0, 0, 0, 1); step();
    tag = "R2";
    setc(0, 0, 0, 0, 0); step();
    // R4 timeout
    tag = "R4";
    setc(0, 0, 1, 0, 0); step();
    setc(0, 1, 1, 1, 0); step();
    fifo = 1; step();
    setc(0, 1, 0, 1, 0); step();
    setc(0, 0, 1, 0, 0); step();
    setc(1, 0, 1, 0, 0); step();
    // R5 upper bits follow mode
    tag = "R5";
    setc(0, 0, 0, 0, 0); fifo = 1; step(); fifo = 0; step();
    // R8 freeze with changes during the read
    tag = "R8";
    setc(0, 0, 0, 1, 0); step();
    rd = 1;
    setc(1, 0, 0, 0, 0); step();
    setc(0, 0, 0, 0, 1); step();
    fifo = 1; step();
    wr = 1; wd = 8'h08; step(); wr = 0;
    rd = 0; step(); step();
    rd = 1; setc(0, 1, 0, 0, 0); writeMask(8'h01); step();
    rd = 0; step();
    // mixed sweep
    tag = "R3";
    seed = 32'h1ACE5;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      setc(seed[16], seed[17], seed[18], seed[19], seed[20]);
      fifo = seed[21];
      rd = seed[22] & seed[23];
      wr = seed[24] & seed[25] & seed[26];
      wd = seed[31:24];
      step();
    end
    rd = 0; wr = 0;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule